// File: doc/BRIEF.md
# Coprocessor Shared-Memory Window Bridge

This block gives a signal-processing coprocessor a narrow window into the main processor's 16-bit memory. The coprocessor talks to it through three I/O ports. A write to the select port stores a segment number and a word offset. The data port then performs one read or one write on the main bus at the stored address. It does this only when the segment is on a short list of permitted segments. Any access outside that list is dropped without a bus cycle. The stored address does not advance by itself, so every access goes to the most recent selection.

The third port drives the coprocessor's branch-test flag. The host processor is halted while the coprocessor works. The coprocessor signals the end of its job by writing zero near the start of the command segment. This arms a handback. A later flag-port write of zero then emits a one-cycle pulse that releases the host from halt. While a main-bus cycle is in flight, the coprocessor-side ready signal is held low.

Top module: `dsp_window_bridge`

## Requirements
- R1: A select-port write (port code 0) stores bits 15:13 of the data as the segment. The bus address is segment × 0x10000 plus the byte offset.
- R2: On the same select-port write, bits 12:0 of the data are the word offset. The byte offset is twice the word offset, so every bus address is even.
- R3: Only segments 3, 4 and 5 (bases 0x30000, 0x40000, 0x50000) are reachable. A data read of any other segment returns 0 with no bus cycle. A data write to any other segment is discarded with no bus cycle.
- R4: Every data-port write (port code 1) first clears the handback flag. The flag is then set if all three hold: the segment is 3, the byte offset is below 3, and the data is 0x0000. Such a write still goes to the bus.
- R5: A flag-port write (port code 3) with bit 15 set drives `bio_active` low.
- R6: A flag-port write of exactly 0x0000 drives `bio_active` high. If the handback flag is set, it also clears the flag and drives `host_release` high for exactly one cycle. Without the flag, no pulse occurs.
- R7: After reset, `bio_active` and `host_release` are 0, no bus request is pending, `dsp_ready` is 1, and segment, offset and flag are 0.
- R8: A permitted data access holds `dsp_ready` low from the cycle after the strobe until the main bus acknowledges. A read then returns the full 16-bit bus word on `dsp_rdata`.
- R9: The stored address never advances by itself. Consecutive data accesses without a new select write use the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dsp_port | input | 2 | Port code: 0 select, 1 data, 3 flag |
| dsp_wr | input | 1 | Write strobe, taken when `dsp_ready` is high |
| dsp_rd | input | 1 | Read strobe, taken when `dsp_ready` is high |
| dsp_wdata | input | 16 | Write data from the coprocessor |
| dsp_rdata | output | 16 | Data returned by the last read |
| dsp_ready | output | 1 | High when a new strobe can be taken |
| bus_req | output | 1 | Main-bus request, held until acknowledged |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | 19 | Main-bus byte address |
| bus_wdata | output | 16 | Main-bus write data |
| bus_rdata | input | 16 | Main-bus read data, valid with `bus_ack` |
| bus_ack | input | 1 | Main-bus acknowledge |
| bio_active | output | 1 | Branch-test flag to the coprocessor, 1 = asserted |
| host_release | output | 1 | One-cycle pulse that releases the host from halt |

## Verification
The bench targets four corner cases:

- **Segment filtering.** It writes and reads every permitted segment and two forbidden ones. A wrong whitelist would show an unexpected bus cycle or a nonzero read from a forbidden segment.
- **Address formation.** It uses the top word offset and offsets that must be repeated without re-selection. A bad shift or an auto-increment would put the bus address at the wrong byte.
- **Arming window.** It tries the handback edges: byte offsets 0 and 2 arm the handback, byte offset 4 does not, and a non-zero write does not. A design that compares the word offset instead of the byte offset, or that forgets to clear the flag on each write, would release the host at the wrong time.
- **Unarmed release.** A flag write of zero with nothing armed must assert the flag without a pulse. A design that pulses unconditionally would free the host early.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
  typedef enum logic [1:0] {
    PORT_SEL   = 2'd0,
    PORT_DATA  = 2'd1,
    PORT_SPARE = 2'd2,
    PORT_FLAG  = 2'd3
  } dwb_port_e;
endpackage

// File: rtl/dwb_addr_latch.sv
module dwb_addr_latch #(
  parameter int DATA_W = 16,
  parameter int SEG_W  = 3,
  localparam int OFF_W = DATA_W - SEG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEG_W-1:0]  seg,
  output logic [OFF_W-1:0]  off
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seg <= '0;
      off <= '0;
    end else if (load) begin
      seg <= wdata[DATA_W-1 -: SEG_W];
      off <= wdata[OFF_W-1:0];
    end
  end
endmodule

// File: rtl/dwb_bus_master.sv
module dwb_bus_master #(
  parameter int DATA_W          = 16,
  parameter int SEG_W           = 3,
  parameter int SEG_SHIFT       = 16,
  parameter logic [(1<<SEG_W)-1:0] ALLOW_MASK = 8'b0011_1000,
  localparam int OFF_W          = DATA_W - SEG_W,
  localparam int ADDR_W         = SEG_W + SEG_SHIFT,
  localparam int PAD_W          = SEG_SHIFT - OFF_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_go,
  input  logic              wr_go,
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  logic              permitted;
  logic [ADDR_W-1:0] target;

  assign permitted = ALLOW_MASK[seg];

  generate
    if (PAD_W > 0) begin : g_pad
      assign target = {seg, {PAD_W{1'b0}}, off, 1'b0};
    end else begin : g_nopad
      assign target = {seg, off, 1'b0};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ready     <= 1'b1;
      rdata     <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (bus_req) begin
      if (bus_ack) begin
        bus_req <= 1'b0;
        ready   <= 1'b1;
        if (!bus_we) rdata <= bus_rdata;
      end
    end else if (rd_go || wr_go) begin
      if (permitted) begin
        bus_req   <= 1'b1;
        ready     <= 1'b0;
        bus_we    <= wr_go;
        bus_addr  <= target;
        bus_wdata <= wdata;
      end else if (rd_go) begin
        rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/dwb_handback.sv
module dwb_handback #(
  parameter int DATA_W         = 16,
  parameter int SEG_W          = 3,
  parameter int ARM_SEG        = 3,
  parameter int ARM_BYTE_LIMIT = 3,
  localparam int OFF_W         = DATA_W - SEG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic              flag_wr,
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic              bio_active,
  output logic              host_release
);
  logic            armed;
  logic [OFF_W:0]  byte_off;
  logic            arm_hit;

  assign byte_off = {off, 1'b0};
  assign arm_hit  = (seg == SEG_W'(ARM_SEG)) &&
                    (byte_off < (OFF_W+1)'(ARM_BYTE_LIMIT)) &&
                    (wdata == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed        <= 1'b0;
      bio_active   <= 1'b0;
      host_release <= 1'b0;
    end else begin
      host_release <= 1'b0;
      if (data_wr) armed <= arm_hit;
      if (flag_wr) begin
        if (wdata[DATA_W-1]) bio_active <= 1'b0;
        if (wdata == '0) begin
          bio_active <= 1'b1;
          if (armed) begin
            host_release <= 1'b1;
            armed        <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dsp_window_bridge.sv
module dsp_window_bridge #(
  parameter int DATA_W         = 16,
  parameter int SEG_W          = 3,
  parameter int SEG_SHIFT      = 16,
  parameter logic [(1<<SEG_W)-1:0] ALLOW_MASK = 8'b0011_1000,
  parameter int ARM_SEG        = 3,
  parameter int ARM_BYTE_LIMIT = 3,
  localparam int OFF_W         = DATA_W - SEG_W,
  localparam int ADDR_W        = SEG_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        dsp_port,
  input  logic              dsp_wr,
  input  logic              dsp_rd,
  input  logic [DATA_W-1:0] dsp_wdata,
  output logic [DATA_W-1:0] dsp_rdata,
  output logic              dsp_ready,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              bio_active,
  output logic              host_release
);
  import dwb_pkg::*;

  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic sel_wr, data_wr, data_rd, flag_wr;

  assign sel_wr  = dsp_ready && dsp_wr && (dsp_port == PORT_SEL);
  assign data_wr = dsp_ready && dsp_wr && (dsp_port == PORT_DATA);
  assign data_rd = dsp_ready && dsp_rd && !dsp_wr && (dsp_port == PORT_DATA);
  assign flag_wr = dsp_ready && dsp_wr && (dsp_port == PORT_FLAG);

  dwb_addr_latch #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_latch (
    .clk(clk), .rst(rst), .load(sel_wr), .wdata(dsp_wdata),
    .seg(seg), .off(off)
  );

  dwb_bus_master #(.DATA_W(DATA_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT),
                   .ALLOW_MASK(ALLOW_MASK)) u_master (
    .clk(clk), .rst(rst), .rd_go(data_rd), .wr_go(data_wr),
    .seg(seg), .off(off), .wdata(dsp_wdata),
    .ready(dsp_ready), .rdata(dsp_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  dwb_handback #(.DATA_W(DATA_W), .SEG_W(SEG_W), .ARM_SEG(ARM_SEG),
                 .ARM_BYTE_LIMIT(ARM_BYTE_LIMIT)) u_handback (
    .clk(clk), .rst(rst), .data_wr(data_wr), .flag_wr(flag_wr),
    .seg(seg), .off(off), .wdata(dsp_wdata),
    .bio_active(bio_active), .host_release(host_release)
  );
endmodule

// File: rtl/dwb_checker.sv
module dwb_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 19,
  parameter int SEG_W  = 3,
  parameter logic [(1<<SEG_W)-1:0] ALLOW_MASK = 8'b0011_1000
) (
  input logic              clk,
  input logic              rst,
  input logic              dsp_ready,
  input logic              bus_req,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bio_active,
  input logic              host_release
);
  p_reset_quiet_r7: assert property (@(posedge clk)
    rst |=> (!bio_active && !host_release && !bus_req && dsp_ready));

  p_even_addr_r2: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !bus_addr[0]);

  p_seg_permitted_r3: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> ALLOW_MASK[bus_addr[ADDR_W-1 -: SEG_W]]);

  p_release_single_r6: assert property (@(posedge clk) disable iff (rst)
    host_release |=> !host_release);

  p_release_with_flag_r6: assert property (@(posedge clk) disable iff (rst)
    host_release |-> bio_active);

  p_stall_during_req_r8: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !dsp_ready);

  p_addr_held_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));
endmodule

bind dsp_window_bridge dwb_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEG_W(SEG_W), .ALLOW_MASK(ALLOW_MASK)
) u_dwb_checker (
  .clk(clk), .rst(rst), .dsp_ready(dsp_ready), .bus_req(bus_req),
  .bus_ack(bus_ack), .bus_addr(bus_addr), .bio_active(bio_active),
  .host_release(host_release)
);

// File: tb/dsp_window_bridge_bench.sv
`timescale 1ns/1ps
module dsp_window_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  dsp_port = 2'd0;
  logic        dsp_wr = 1'b0;
  logic        dsp_rd = 1'b0;
  logic [15:0] dsp_wdata = '0;
  logic [15:0] dsp_rdata;
  logic        dsp_ready;
  logic        bus_req, bus_we;
  logic [18:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_ack;
  logic        bio_active, host_release;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dsp_window_bridge u_dsp_window_bridge (
    .clk(clk), .rst(rst), .dsp_port(dsp_port), .dsp_wr(dsp_wr), .dsp_rd(dsp_rd),
    .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata), .dsp_ready(dsp_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bio_active(bio_active), .host_release(host_release)
  );

  typedef struct packed { logic we; logic [18:0] addr; logic [15:0] data; } bus_item_t;
  bus_item_t   exp_q[$];
  logic [15:0] mem [int];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: behavioural RAM pops each expected bus cycle.
  always @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        bus_ack <= 1'b1;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R3: actual unexpected bus cycle at %0h expected none", bus_addr);
        end else begin
          bus_item_t e;
          e = exp_q.pop_front();
          if (e.we !== bus_we || e.addr !== bus_addr || (e.we && e.data !== bus_wdata)) begin
            fails++;
            $display("FAIL R1/R2: actual we=%0b addr=%0h data=%0h expected we=%0b addr=%0h data=%0h",
                     bus_we, bus_addr, bus_wdata, e.we, e.addr, e.data);
          end
        end
        if (bus_we) mem[int'(bus_addr)] = bus_wdata;
        else bus_rdata <= mem.exists(int'(bus_addr)) ? mem[int'(bus_addr)] : 16'h0;
      end
    end
  end

  always @(negedge clk) if (!rst && host_release) pulses++;

  task automatic wait_ready();
    while (!dsp_ready) @(negedge clk);
  endtask

  task automatic port_wr(input logic [1:0] p, input logic [15:0] d);
    wait_ready();
    dsp_port = p; dsp_wdata = d; dsp_wr = 1'b1;
    @(negedge clk);
    dsp_wr = 1'b0;
    wait_ready();
  endtask

  task automatic port_rd(output logic [15:0] d);
    wait_ready();
    dsp_port = 2'd1; dsp_rd = 1'b1;
    @(negedge clk);
    dsp_rd = 1'b0;
    wait_ready();
    d = dsp_rdata;
  endtask

  function automatic logic [15:0] sel(input int s, input int w);
    return {3'(s), 13'(w)};
  endfunction

  function automatic logic [18:0] baddr(input int s, input int w);
    return 19'((s << 16) + (w << 1));
  endfunction

  task automatic expect_bus(input logic we, input logic [18:0] a, input logic [15:0] d);
    exp_q.push_back('{we: we, addr: a, data: d});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check("R7 bio", bio_active, 0);
    check("R7 release", host_release, 0);
    check("R7 ready", dsp_ready, 1);
    check("R7 req", bus_req, 0);
    // R7: segment/offset zero -> segment 0 forbidden, read gives 0, no bus cycle
    port_rd(rd);
    check("R7 zero segment read", rd, 0);

    // R1 R2 writes and reads in each permitted segment
    port_wr(2'd0, sel(3, 5));
    expect_bus(1, baddr(3, 5), 16'hA5C3);
    dsp_port = 2'd1; dsp_wdata = 16'hA5C3; dsp_wr = 1'b1;
    @(negedge clk); dsp_wr = 1'b0;
    check("R8 ready stalls", dsp_ready, 0);
    wait_ready();
    expect_bus(0, baddr(3, 5), 0);
    port_rd(rd);
    check("R8 full word read", rd, 16'hA5C3);

    port_wr(2'd0, sel(4, 16'h0123));
    expect_bus(1, baddr(4, 16'h0123), 16'h1234);
    port_wr(2'd1, 16'h1234);
    port_wr(2'd0, sel(5, 16'h1FFF));
    expect_bus(1, 19'h53FFE, 16'hBEEF);
    port_wr(2'd1, 16'hBEEF);
    expect_bus(0, 19'h53FFE, 0);
    port_rd(rd);
    check("R2 top offset read", rd, 16'hBEEF);
    port_wr(2'd0, sel(4, 16'h0123));
    expect_bus(0, baddr(4, 16'h0123), 0);
    port_rd(rd);
    check("R1 segment 4 read", rd, 16'h1234);

    // R9 no auto increment: two reads same address
    expect_bus(0, baddr(4, 16'h0123), 0);
    port_rd(rd);
    check("R9 repeat read", rd, 16'h1234);

    // R3 forbidden segments
    mem[int'(19'h60010)] = 16'h7777;
    port_wr(2'd0, sel(6, 8));
    port_wr(2'd1, 16'h5555);
    port_rd(rd);
    check("R3 seg6 read", rd, 0);
    port_wr(2'd0, sel(2, 1));
    port_rd(rd);
    check("R3 seg2 read", rd, 0);
    check("R3 seg6 unchanged", mem[int'(19'h60010)], 16'h7777);
    check("R3 no pending", exp_q.size(), 0);

    // R5 bit15 deasserts, R6 unarmed zero write asserts without pulse
    p0 = pulses;
    port_wr(2'd3, 16'h0000);
    @(negedge clk);
    check("R6 bio asserted", bio_active, 1);
    check("R6 unarmed no pulse", pulses - p0, 0);
    port_wr(2'd3, 16'h8000);
    check("R5 bio cleared", bio_active, 0);

    // R4 R6 arm at byte offset 0 then release
    port_wr(2'd0, sel(3, 0));
    expect_bus(1, baddr(3, 0), 0);
    port_wr(2'd1, 16'h0000);
    port_wr(2'd3, 16'hFFFF);
    check("R6 arm survives bit15 write, no pulse", pulses - p0, 0);
    port_wr(2'd3, 16'h0000);
    check("R6 release pulse", host_release, 1);
    @(negedge clk);
    check("R6 pulse one cycle", host_release, 0);
    check("R6 one pulse", pulses - p0, 1);
    port_wr(2'd3, 16'h0000);
    @(negedge clk);
    check("R6 flag cleared after release", pulses - p0, 1);

    // R4 arm at byte offset 2 works
    port_wr(2'd0, sel(3, 1));
    expect_bus(1, baddr(3, 1), 0);
    port_wr(2'd1, 16'h0000);
    port_wr(2'd3, 16'h0000);
    @(negedge clk);
    check("R4 byte offset 2 arms", pulses - p0, 2);

    // R4 byte offset 4 does not arm
    port_wr(2'd0, sel(3, 2));
    expect_bus(1, baddr(3, 2), 0);
    port_wr(2'd1, 16'h0000);
    port_wr(2'd3, 16'h0000);
    @(negedge clk);
    check("R4 byte offset 4 no arm", pulses - p0, 2);

    // R4 non-zero data does not arm
    port_wr(2'd0, sel(3, 0));
    expect_bus(1, baddr(3, 0), 16'h0001);
    port_wr(2'd1, 16'h0001);
    port_wr(2'd3, 16'h0000);
    @(negedge clk);
    check("R4 nonzero no arm", pulses - p0, 2);

    // R4 later write clears the arm
    expect_bus(1, baddr(3, 0), 16'h0000);
    port_wr(2'd1, 16'h0000);
    port_wr(2'd0, sel(4, 0));
    expect_bus(1, baddr(4, 0), 16'h0000);
    port_wr(2'd1, 16'h0000);
    port_wr(2'd3, 16'h0000);
    @(negedge clk);
    check("R4 rewrite clears arm", pulses - p0, 2);

    // R4 forbidden-segment write also clears arm
    port_wr(2'd0, sel(3, 0));
    expect_bus(1, baddr(3, 0), 16'h0000);
    port_wr(2'd1, 16'h0000);
    port_wr(2'd0, sel(7, 0));
    port_wr(2'd1, 16'h0000);
    port_wr(2'd3, 16'h0000);
    @(negedge clk);
    check("R4 dropped write clears arm", pulses - p0, 2);

    repeat (4) @(negedge clk);
    check("R3 all bus cycles seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule